// File: doc/BRIEF.md
# Bidirectional Register Transceiver Channel

This block connects two parallel buses, side A and side B, through two independent one-way channels. Each channel has one storage element. A channel-local latch enable, bus clock and clock enable pick how that element behaves:

- **Transparent:** the element follows its source side.
- **Hold:** the element keeps its contents.
- **Edge capture:** the element loads the source side on a rising edge of the bus clock.

A separate active-low output enable per channel controls whether the destination side is driven. Three-state pins are modelled as separate input, output and drive-enable vectors on each side. The width is a parameter.

All logic runs on one system clock. Each bus clock is sampled on every system edge, and a rising edge is taken to be a high sample whose previous sample was low. The element always drives the destination output. In transparent mode the output therefore shows the source value one system clock after it is sampled. The drive-enable is registered, so it also follows its output-enable pin with one cycle of latency.

Top module: `bidir_xcvr`

## Requirements
- R1: A synchronous active-low reset clears both storage elements to zero and deasserts every bit of both drive-enables on the following cycle.
- R2: While `le_ab` is 1 at a system clock edge, `b_out` after that edge equals `a_in` sampled at that edge.
- R3: While `le_ab` is 0 and no rising edge of `clk_ab` is seen, `b_out` keeps its value. A falling edge or a steady level of `clk_ab` changes nothing.
- R4: While `le_ab` is 0 and `ce_ab_n` is 0, a rising edge of `clk_ab` loads `a_in` into the A-to-B element. A rising edge means a sample of 1 whose previous system-clock sample was 0.
- R5: A rising edge of `clk_ab` that occurs while `ce_ab_n` is 1 leaves `b_out` unchanged.
- R6: When `le_ab` is 1, transparent behaviour takes priority over any edge of `clk_ab`.
- R7: After each system clock edge out of reset, every bit of `b_de` equals the inverse of `oe_ab_n`, and every bit of `a_de` equals the inverse of `oe_ba_n`, as sampled at that edge.
- R8: The B-to-A channel obeys R2 through R6 using `b_in`, `a_out`, `le_ba`, `clk_ba` and `ce_ba_n`.
- R9: Activity on the controls and data of one channel has no effect on the output of the other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | W | Side A sampled pin value |
| a_out | output | W | Value driven onto side A (B-to-A storage) |
| a_de | output | W | Side A drive-enable, 1 = drive |
| b_in | input | W | Side B sampled pin value |
| b_out | output | W | Value driven onto side B (A-to-B storage) |
| b_de | output | W | Side B drive-enable, 1 = drive |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| le_ab | input | 1 | A-to-B latch enable, 1 = transparent |
| clk_ab | input | 1 | A-to-B bus clock |
| ce_ab_n | input | 1 | A-to-B clock enable, active low |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| le_ba | input | 1 | B-to-A latch enable, 1 = transparent |
| clk_ba | input | 1 | B-to-A bus clock |
| ce_ba_n | input | 1 | B-to-A clock enable, active low |

## Verification
The assertions assume that each bus clock is already stable at the system clock's rate. They also assume the system clock samples it often enough that every high and every low phase lasts at least one system cycle, because only then does a detected rising edge match a real one.

The stimulus meets this assumption by design. It changes the bus-clock pins once per system cycle, between edges, so every level it presents is sampled at least once.

The sweep drives every combination of latch enable, clock level, clock enable and output enable on both channels together. The data on both sides comes from a pseudo-random sequence.

// File: rtl/bxcvr_pkg.sv
package bxcvr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PASS = 2'd1,
    OP_CAPT = 2'd2
  } store_op_e;

  // Transparent mode outranks the clock; a clock edge needs the enable low.
  function automatic store_op_e pick_op(input logic le, input logic rise, input logic ce_n);
    if (le)               return OP_PASS;
    else if (rise && !ce_n) return OP_CAPT;
    else                  return OP_HOLD;
  endfunction

  function automatic logic is_rise(input logic now_s, input logic prev_s);
    return now_s & ~prev_s;
  endfunction

endpackage

// File: rtl/bxcvr_edge.sv
module bxcvr_edge (
  input  logic clk,
  input  logic bus_clk,
  output logic rise
);
  import bxcvr_pkg::*;

  logic prev_q;

  always_ff @(posedge clk) prev_q <= bus_clk;

  assign rise = is_rise(bus_clk, prev_q);
endmodule

// File: rtl/bxcvr_store.sv
module bxcvr_store #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic         rise,
  input  logic         ce_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         load
);
  import bxcvr_pkg::*;

  store_op_e    op;
  logic [W-1:0] mem_q;

  assign op   = pick_op(le, rise, ce_n);
  assign load = (op != OP_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n)    mem_q <= '0;
    else if (load) mem_q <= din;
  end

  assign dout = mem_q;
endmodule

// File: rtl/bxcvr_drive.sv
module bxcvr_drive #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  output logic [W-1:0] de
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= ~oe_n;
  end

  assign de = {W{en_q}};
endmodule

// File: rtl/bxcvr_lane.sv
module bxcvr_lane #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] dst,
  output logic [W-1:0] dst_de,
  input  logic         oe_n,
  input  logic         le,
  input  logic         bus_clk,
  input  logic         ce_n,
  output logic         rise,
  output logic         load
);
  bxcvr_edge u_edge (
    .clk     (clk),
    .bus_clk (bus_clk),
    .rise    (rise)
  );

  bxcvr_store #(.W(W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .le    (le),
    .rise  (rise),
    .ce_n  (ce_n),
    .din   (src),
    .dout  (dst),
    .load  (load)
  );

  bxcvr_drive #(.W(W)) u_drive (
    .clk   (clk),
    .rst_n (rst_n),
    .oe_n  (oe_n),
    .de    (dst_de)
  );
endmodule

// File: rtl/bidir_xcvr.sv
module bidir_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_de,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_de,
  input  logic         oe_ab_n,
  input  logic         le_ab,
  input  logic         clk_ab,
  input  logic         ce_ab_n,
  input  logic         oe_ba_n,
  input  logic         le_ba,
  input  logic         clk_ba,
  input  logic         ce_ba_n
);
  // Named internal events, brought out for the checker.
  logic ab_rise, ba_rise;
  logic ab_load, ba_load;

  bxcvr_lane #(.W(W)) u_ab (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (a_in),
    .dst     (b_out),
    .dst_de  (b_de),
    .oe_n    (oe_ab_n),
    .le      (le_ab),
    .bus_clk (clk_ab),
    .ce_n    (ce_ab_n),
    .rise    (ab_rise),
    .load    (ab_load)
  );

  bxcvr_lane #(.W(W)) u_ba (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (b_in),
    .dst     (a_out),
    .dst_de  (a_de),
    .oe_n    (oe_ba_n),
    .le      (le_ba),
    .bus_clk (clk_ba),
    .ce_n    (ce_ba_n),
    .rise    (ba_rise),
    .load    (ba_load)
  );
endmodule

// File: rtl/bidir_xcvr_chk.sv
module bidir_xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_de,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_de,
  input logic         oe_ab_n,
  input logic         le_ab,
  input logic         ce_ab_n,
  input logic         oe_ba_n,
  input logic         le_ba,
  input logic         ce_ba_n,
  input logic         ab_rise,
  input logic         ba_rise
);
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (a_out == '0 && b_out == '0 && a_de == '0 && b_de == '0));

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    le_ab |=> b_out == $past(a_in));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && !ab_rise) |=> $stable(b_out));

  p_capt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && ab_rise && !ce_ab_n) |=> b_out == $past(a_in));

  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && ce_ab_n) |=> $stable(b_out));

  p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (le_ab && ab_rise && ce_ab_n) |=> b_out == $past(a_in));

  p_de_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> b_de == {W{~$past(oe_ab_n)}});

  p_de_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> a_de == {W{~$past(oe_ba_n)}});

  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    le_ba |=> a_out == $past(b_in));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ba && !ba_rise) |=> $stable(a_out));

  p_capt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ba && ba_rise && !ce_ba_n) |=> a_out == $past(b_in));

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ba && ce_ba_n) |=> $stable(a_out));
endmodule

bind bidir_xcvr bidir_xcvr_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_in    (a_in),
  .a_out   (a_out),
  .a_de    (a_de),
  .b_in    (b_in),
  .b_out   (b_out),
  .b_de    (b_de),
  .oe_ab_n (oe_ab_n),
  .le_ab   (le_ab),
  .ce_ab_n (ce_ab_n),
  .oe_ba_n (oe_ba_n),
  .le_ba   (le_ba),
  .ce_ba_n (ce_ba_n),
  .ab_rise (ab_rise),
  .ba_rise (ba_rise)
);

// File: tb/bidir_xcvr_tb.sv
module bidir_xcvr_tb;
  localparam int W        = 8;
  localparam int CLK_PER  = 10;
  localparam int WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, a_de, b_out, b_de;
  logic         oe_ab_n, le_ab, clk_ab, ce_ab_n;
  logic         oe_ba_n, le_ba, clk_ba, ce_ba_n;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  // Reference state, kept by the bench.
  logic [W-1:0] m_b, m_a, m_bde, m_ade;
  logic         m_pab, m_pba;

  always #(CLK_PER/2) clk = ~clk;

  bidir_xcvr #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_de(a_de),
    .b_in(b_in), .b_out(b_out), .b_de(b_de),
    .oe_ab_n(oe_ab_n), .le_ab(le_ab), .clk_ab(clk_ab), .ce_ab_n(ce_ab_n),
    .oe_ba_n(oe_ba_n), .le_ba(le_ba), .clk_ba(clk_ba), .ce_ba_n(ce_ba_n)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic rst, input logic le,
                                   input logic clk_now, input logic clk_prv,
                                   input logic cen);
    logic r;
    r = clk_now & !clk_prv;
    if (!rst)         return "R1";
    if (le && r)      return "R6";
    if (le)           return "R2";
    if (r && !cen)    return "R4";
    if (r)            return "R5";
    return "R3";
  endfunction

  // One system cycle: inputs already applied at a negedge; predict, clock, compare.
  task automatic step();
    logic [W-1:0] nb, na;
    string tb_tag, ta_tag;
    nb = m_b; na = m_a;
    tb_tag = tag_of(rst_n, le_ab, clk_ab, m_pab, ce_ab_n);
    ta_tag = tag_of(rst_n, le_ba, clk_ba, m_pba, ce_ba_n);
    if (!rst_n) begin
      nb = '0; na = '0;
    end else begin
      if (le_ab || (clk_ab && !m_pab && !ce_ab_n)) nb = a_in;
      if (le_ba || (clk_ba && !m_pba && !ce_ba_n)) na = b_in;
    end
    m_bde = rst_n ? {W{~oe_ab_n}} : '0;
    m_ade = rst_n ? {W{~oe_ba_n}} : '0;
    m_pab = clk_ab; m_pba = clk_ba;
    m_b = nb; m_a = na;
    @(posedge clk);
    @(negedge clk);
    chk(tb_tag, b_out, m_b);
    chk((rst_n ? "R8" : "R1"), a_out, m_a);
    chk((rst_n ? "R7" : "R1"), b_de, m_bde);
    chk((rst_n ? "R7" : "R1"), a_de, m_ade);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    rst_n = 0; a_in = '0; b_in = '0;
    oe_ab_n = 1; le_ab = 0; clk_ab = 0; ce_ab_n = 1;
    oe_ba_n = 1; le_ba = 0; clk_ba = 0; ce_ba_n = 1;
    m_b = '0; m_a = '0; m_bde = '0; m_ade = '0; m_pab = 0; m_pba = 0;
    @(negedge clk);
    // R1: reset state
    step(); step();
    rst_n = 1;

    // R2: transparent, two values
    le_ab = 1; a_in = 8'h5A; step();
    a_in = 8'hC3; step();
    // R3: drop to latched, input changes, output holds
    le_ab = 0; a_in = 8'h11; step();
    a_in = 8'h22; step();
    // R4: rising edge with enable low captures
    ce_ab_n = 0; clk_ab = 1; a_in = 8'h77; step();
    chk("R4", b_out, 8'h77);
    // R3: clock held high, then falling edge: no change
    a_in = 8'h99; step();
    clk_ab = 0; step();
    chk("R3", b_out, 8'h77);
    // R5: rising edge with enable high is ignored
    ce_ab_n = 1; clk_ab = 1; a_in = 8'h3C; step();
    chk("R5", b_out, 8'h77);
    // R6: latch enable overrides, edge irrelevant
    clk_ab = 0; step();
    le_ab = 1; clk_ab = 1; ce_ab_n = 0; a_in = 8'hE4; step();
    chk("R6", b_out, 8'hE4);
    // R7: output enables toggle on both sides
    oe_ab_n = 0; step();
    chk("R7", b_de, {W{1'b1}});
    oe_ba_n = 0; oe_ab_n = 1; step();
    chk("R7", a_de, {W{1'b1}});
    chk("R7", b_de, '0);
    // R8: B-to-A path transparent then capture
    le_ab = 0; clk_ab = 0;
    le_ba = 1; b_in = 8'h6D; step();
    chk("R8", a_out, 8'h6D);
    le_ba = 0; ce_ba_n = 0; step();
    clk_ba = 1; b_in = 8'hB2; step();
    chk("R8", a_out, 8'hB2);
    // R9: AB churn leaves a_out alone
    clk_ba = 0; ce_ba_n = 1;
    for (int i = 0; i < 6; i++) begin
      le_ab = i[0]; clk_ab = i[1]; ce_ab_n = 0; a_in = 8'(i * 37); b_in = 8'(i * 11);
      step();
      chk("R9", a_out, 8'hB2);
    end

    // Near-exhaustive sweep of all control combinations on both paths.
    for (int k = 0; k < 4096; k++) begin
      lfsr = nxt(lfsr);
      {le_ab, clk_ab, ce_ab_n, oe_ab_n} = 4'(k);
      {le_ba, clk_ba, ce_ba_n, oe_ba_n} = 4'(k >> 4) ^ lfsr[3:0];
      a_in = lfsr[15:8];
      b_in = lfsr[7:0] ^ 8'(k);
      rst_n = (k % 1000) != 999;
      step();
    end
    rst_n = 1;

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule